// File: doc/BRIEF.md
# Line-Band Negative and Blink Unit

This unit sits on the pixel path between display memory and the segment drivers and alters the look of a horizontal band of lines. The band is bounded by a first-line and a last-line setting and switched on by an enable bit. A mode bit selects the effect. One mode shows the band in negative tone all the time. The other mode makes the band blink, alternating between normal and negative every 32 frames.

Each pixel word holds `NCH` grey-level channels of `GW` bits. Negative tone is the bitwise complement of each channel. Columns flagged as dummy-segment columns always pass through unaltered. Settings on the configuration inputs are captured only on the frame-start strobe, so a frame never shows a half-applied setting. The pixel output is combinational from the pixel, line and dummy inputs, so it adds no latency to the pixel path.

Top module: `line_band_fx`

## Requirements
- R1: After reset every captured setting is zero and the blink phase is "normal", so `pix_o` equals `pix_i` for any line.
- R2: With the captured enable bit at 0, `pix_o` equals `pix_i` on every line in both modes.
- R3: With enable 1 and mode bit 0, a line with `band_first <= line <= band_last` (both limits included) outputs `~pix_i`, the complement of every grey-level channel.
- R4: Lines outside the band pass through unchanged, and a first-line value greater than the last-line value leaves every line unchanged.
- R5: With enable 1 and mode bit 1, band lines show `pix_i` while the blink phase is 0 and `~pix_i` while it is 1. A 5-bit frame counter advances on each frame-start strobe. The phase toggles on every 32nd strobe, when the counter wraps from 31 to 0. The first 31 strobes after reset leave the phase at 0.
- R6: When `dummy_col_i` is 1, `pix_o` equals `pix_i` whatever the enable, mode and band settings are.
- R7: The configuration inputs are captured only at a clock edge where `frame_start_i` is 1. Changes made between strobes do not affect `pix_o` until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle strobe at the start of each frame |
| cfg_en_i | input | 1 | Band effect enable (captured at frame start) |
| cfg_mode_i | input | 1 | 0 = steady negative, 1 = 32-frame blink |
| cfg_first_i | input | LINE_W | First line of the band, included |
| cfg_last_i | input | LINE_W | Last line of the band, included |
| line_i | input | LINE_W | Line number of the current pixel |
| dummy_col_i | input | 1 | Marks a dummy-segment column |
| pix_i | input | NCH*GW | Pixel word from display memory |
| pix_o | output | NCH*GW | Pixel word to the segment drivers |

## Verification
The assertions assume that `frame_start_i` is a single-cycle pulse synchronous to `clk_i`, and that the configuration, line and pixel inputs are settled at each rising edge. The bench drives every input on the falling edge and raises the strobe for exactly one cycle. It samples `pix_o` one nanosecond later, so each observation falls between two rising edges. For the blink checks, the bench resets first and then counts its own strobes, so it knows the phase without reading any internal state.

// File: rtl/line_band_fx_pkg.sv
package line_band_fx_pkg;
  typedef enum logic {
    FX_NEGATIVE = 1'b0,
    FX_BLINK    = 1'b1
  } fx_mode_e;
endpackage

// File: rtl/lbf_cfg_shadow.sv
module lbf_cfg_shadow
  import line_band_fx_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [LINE_W-1:0] first_i,
  input  logic [LINE_W-1:0] last_i,
  output logic              en_o,
  output fx_mode_e          mode_o,
  output logic [LINE_W-1:0] first_o,
  output logic [LINE_W-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      mode_o  <= FX_NEGATIVE;
      first_o <= '0;
      last_o  <= '0;
    end else if (load_i) begin
      en_o    <= en_i;
      mode_o  <= fx_mode_e'(mode_i);
      first_o <= first_i;
      last_o  <= last_i;
    end
  end

  // R7: shadow only moves on a frame start
  a_r7_hold_between_frames: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable({en_o, mode_o, first_o, last_o}));
  a_r7_load_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (en_o == $past(en_i)) && (first_o == $past(first_i)) && (last_o == $past(last_i)));
endmodule

// File: rtl/lbf_blink_timer.sv
module lbf_blink_timer #(
  parameter int PERIOD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic phase_o
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = tick_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) phase_o <= ~phase_o;
    end
  end

  a_r5_phase_flips_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q == CNT_MAX) |=> phase_o != $past(phase_o));
  a_r5_phase_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && cnt_q == CNT_MAX) |=> $stable(phase_o));
  a_r5_count_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/lbf_band_match.sv
module lbf_band_match #(
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] first_i,
  input  logic [LINE_W-1:0] last_i,
  output logic              hit_o
);
  // both limits included; first > last yields an empty band
  assign hit_o = (line_i >= first_i) && (line_i <= last_i);
endmodule

// File: rtl/line_band_fx.sv
module line_band_fx
  import line_band_fx_pkg::*;
#(
  parameter int LINE_W       = 8,
  parameter int GW           = 6,
  parameter int NCH          = 3,
  parameter int BLINK_FRAMES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              cfg_en_i,
  input  logic              cfg_mode_i,
  input  logic [LINE_W-1:0] cfg_first_i,
  input  logic [LINE_W-1:0] cfg_last_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              dummy_col_i,
  input  logic [NCH*GW-1:0] pix_i,
  output logic [NCH*GW-1:0] pix_o
);
  localparam int PW = NCH * GW;

  logic              en_q;
  fx_mode_e          mode_q;
  logic [LINE_W-1:0] first_q, last_q;
  logic              phase;
  logic              hit;
  logic              flip;

  lbf_cfg_shadow #(.LINE_W(LINE_W)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (frame_start_i),
    .en_i    (cfg_en_i),
    .mode_i  (cfg_mode_i),
    .first_i (cfg_first_i),
    .last_i  (cfg_last_i),
    .en_o    (en_q),
    .mode_o  (mode_q),
    .first_o (first_q),
    .last_o  (last_q)
  );

  lbf_blink_timer #(.PERIOD(BLINK_FRAMES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (frame_start_i),
    .phase_o (phase)
  );

  lbf_band_match #(.LINE_W(LINE_W)) u_match (
    .line_i  (line_i),
    .first_i (first_q),
    .last_i  (last_q),
    .hit_o   (hit)
  );

  // dummy columns bypass both enable and mode
  assign flip = en_q && hit && !dummy_col_i && ((mode_q == FX_NEGATIVE) || phase);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pix_o[c*GW +: GW] = flip ? ~pix_i[c*GW +: GW] : pix_i[c*GW +: GW];
  end

  a_r6_dummy_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_col_i |-> pix_o == pix_i);
  a_r2_disabled_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> pix_o == pix_i);
  a_r4_empty_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_q > last_q) |-> pix_o == pix_i);
  a_r3_only_two_outcomes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o == pix_i) || (pix_o == PW'(~pix_i)));
endmodule

// File: tb/sim_line_band_fx.sv
module sim_line_band_fx;
  localparam int LW = 8;
  localparam int PW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fs = 1'b0;
  logic          en = 1'b0;
  logic          mode = 1'b0;
  logic [LW-1:0] first = '0;
  logic [LW-1:0] last = '0;
  logic [LW-1:0] line = '0;
  logic          dmy = 1'b0;
  logic [PW-1:0] pin = '0;
  logic [PW-1:0] pout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_band_fx u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .cfg_en_i(en),
    .cfg_mode_i(mode), .cfg_first_i(first), .cfg_last_i(last),
    .line_i(line), .dummy_col_i(dmy), .pix_i(pin), .pix_o(pout)
  );

  task automatic chk(string req, logic [PW-1:0] exp);
    n_chk++;
    if (pout !== exp) begin
      n_bad++;
      $display("FAIL %s: pix_o=%h expected %h (line %0d)", req, pout, exp, line);
    end
  endtask

  task automatic probe(logic [LW-1:0] ln, logic [PW-1:0] p, logic d, logic inv, string req);
    @(negedge clk);
    line = ln; pin = p; dmy = d;
    #1 chk(req, inv ? ~p : p);
  endtask

  task automatic frame();
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
  endtask

  task automatic setcfg(logic e, logic m, logic [LW-1:0] f, logic [LW-1:0] l);
    @(negedge clk);
    en = e; mode = m; first = f; last = l;
  endtask

  task automatic t_reset();
    @(negedge clk) rst_n = 1'b0;
    fs = 1'b0; en = 1'b0; mode = 1'b0; first = '0; last = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    probe(8'd0, 18'h2A5C3, 1'b0, 1'b0, "R1");
    probe(8'd200, 18'h3FFFF, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_disabled();
    setcfg(1'b0, 1'b0, 8'd0, 8'd255);
    frame();
    probe(8'd50, 18'h12345, 1'b0, 1'b0, "R2");
    setcfg(1'b0, 1'b1, 8'd0, 8'd255);
    frame();
    probe(8'd7, 18'h0F0F0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_negative();
    setcfg(1'b1, 1'b0, 8'd10, 8'd20);
    frame();
    probe(8'd9,  18'h11111, 1'b0, 1'b0, "R4");
    probe(8'd10, 18'h11111, 1'b0, 1'b1, "R3");
    probe(8'd15, 18'h00000, 1'b0, 1'b1, "R3");
    probe(8'd20, 18'h3F03F, 1'b0, 1'b1, "R3");
    probe(8'd21, 18'h3F03F, 1'b0, 1'b0, "R4");
    probe(8'd255, 18'h2AAAA, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_empty();
    setcfg(1'b1, 1'b0, 8'd30, 8'd29);
    frame();
    probe(8'd29, 18'h15555, 1'b0, 1'b0, "R4");
    probe(8'd30, 18'h15555, 1'b0, 1'b0, "R4");
    setcfg(1'b1, 1'b0, 8'd40, 8'd40);
    frame();
    probe(8'd40, 18'h15555, 1'b0, 1'b1, "R3");
  endtask

  task automatic t_dummy();
    setcfg(1'b1, 1'b0, 8'd0, 8'd255);
    frame();
    probe(8'd100, 18'h3C3C3, 1'b1, 1'b0, "R6");
    probe(8'd100, 18'h3C3C3, 1'b0, 1'b1, "R3");
  endtask

  task automatic t_deferred();
    setcfg(1'b1, 1'b0, 8'd10, 8'd20);
    frame();
    setcfg(1'b0, 1'b0, 8'd10, 8'd20);
    repeat (3) @(negedge clk);
    probe(8'd12, 18'h0ABCD, 1'b0, 1'b1, "R7");
    setcfg(1'b1, 1'b0, 8'd50, 8'd60);
    probe(8'd12, 18'h0ABCD, 1'b0, 1'b1, "R7");
    frame();
    probe(8'd12, 18'h0ABCD, 1'b0, 1'b0, "R7");
    probe(8'd55, 18'h0ABCD, 1'b0, 1'b1, "R7");
  endtask

  task automatic t_blink();
    t_reset();
    setcfg(1'b1, 1'b1, 8'd10, 8'd20);
    frame();  // strobe 1
    probe(8'd15, 18'h01234, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 30; i++) frame();  // strobe 31
    probe(8'd15, 18'h01234, 1'b0, 1'b0, "R5");
    frame();  // strobe 32: phase 1
    probe(8'd15, 18'h01234, 1'b0, 1'b1, "R5");
    probe(8'd9,  18'h01234, 1'b0, 1'b0, "R5");
    probe(8'd15, 18'h01234, 1'b1, 1'b0, "R6");
    for (int i = 0; i < 31; i++) frame();  // strobe 63
    probe(8'd20, 18'h3FFFF, 1'b0, 1'b1, "R5");
    frame();  // strobe 64: phase 0
    probe(8'd20, 18'h3FFFF, 1'b0, 1'b0, "R5");
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_negative();
    t_empty();
    t_dummy();
    t_deferred();
    t_blink();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule